// File: doc/BRIEF.md
# Send-DMA Abort Recovery Sequencer

This block brings a send DMA engine back into service after an abort. Once an abort request arrives, it raises a busy flag. Upstream logic uses that flag to refuse new submissions. The sequencer then waits for the engine to say it has stopped. If that indication never comes within a tick budget, it carries on as though the engine had stopped.

Next it polls a 64-bit engine status word until four bits show the engine is idle. A second tick budget bounds this polling, and recovery continues when that budget runs out. The recovery pass then runs a fixed sequence, one step per clock:
- flush every in-flight request as aborted, and clear the ring pointers and generation;
- rewrite the ring length/generation-check control word;
- drop the engine enable for one cycle, then restore it, with a read-back strobe after each enable write;
- clear busy.

A shutdown input freezes the sequencer wherever it is. An abort request that arrives while a pass is already running is remembered. A second pass starts as soon as the first one has returned to idle.

Top module: `dma_abort_seq`

## Requirements
- R1: While reset is asserted and right after it, busy, flush_all, ptr_reset, lengen_wr and readback are 0 and eng_enable is 1.
- R2: In idle with shutdown low, an abort_req sampled at a clock edge makes busy 1 from that edge on, and the sequencer waits for the disable indication.
- R3: While it waits, eng_disabled high at an edge moves it to status polling at that edge.
- R4: If eng_disabled stays low, each tick spends one unit of a TIMEOUT_TICKS budget. Once the budget is zero, the next edge moves to status polling anyway.
- R5: The status counts as quiescent only when bits 63, 62 and 61 of hw_status are 0 and bit 30 is 1. A quiescent status during polling starts recovery at the next edge.
- R6: While the status is not quiescent, each tick spends one unit of a RETRY_MAX budget. Once the budget is zero, recovery starts at the next edge anyway.
- R7: Recovery starts with one cycle in which flush_all and ptr_reset are both 1. The next cycle has lengen_wr 1, with lengen_data equal to RING_COUNT OR (1 << 18).
- R8: The cycle after the length write has eng_enable 0. The cycle after that has eng_enable 1 again. readback is 1 in both of those cycles and 0 otherwise.
- R9: busy stays 1 from the abort to the enable-restore cycle inclusive, then drops to 0.
- R10: While shutdown is 1, no state changes and no budget is spent: the outputs stay exactly as they were.
- R11: An abort_req sampled while busy is remembered. One more full pass begins at the edge after busy drops.
- R12: An abort_req sampled in idle while shutdown is 1 is ignored, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_req | input | 1 | Request to start an abort recovery pass |
| eng_disabled | input | 1 | Engine reports it has stopped |
| hw_status | input | STATUS_W | Engine status word |
| tick | input | 1 | Time base for the timeout and retry budgets |
| shutdown | input | 1 | Freezes the sequencer |
| busy | output | 1 | Abort in progress; new submissions are refused |
| flush_all | output | 1 | Complete all in-flight requests as aborted |
| ptr_reset | output | 1 | Clear head, tail, written-back head and generation; set removed equal to added |
| lengen_wr | output | 1 | Write strobe for the length/generation control word |
| lengen_data | output | LENGEN_W | Value to write: ring count with the generation-check bit set |
| eng_enable | output | 1 | Engine enable level |
| readback | output | 1 | Read-back strobe that follows each enable write |
| shutdown | | | |

## Verification
A sequencer state that is wrong by even one step shows up at the ports within a clock. Each recovery step has its own strobe pattern, so any skipped, repeated or reordered step changes flush_all, lengen_wr, eng_enable or readback in that same cycle. A budget counter that miscounts moves the whole recovery burst earlier or later by at least one tick. A lost pending abort shows as busy staying low after the first pass. The bench follows an independent model every cycle, so these faults appear in the first cycle where they differ.

// File: rtl/abort_seq_pkg.sv
package abort_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DISARM,
    S_CHECK,
    S_FLUSH,
    S_LENGEN,
    S_ENOFF,
    S_ENON
  } seq_state_e;
endpackage

// File: rtl/seq_down_counter.sv
module seq_down_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (dec && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load || dec)
      cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // a_r4_no_underflow (also covers R6): spending at zero leaves zero
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && dec && !load) |=> zero);
endmodule

// File: rtl/quiesce_eval.sv
module quiesce_eval #(
  parameter int STATUS_W   = 64,
  parameter int DRAIN_BIT  = 63,
  parameter int ABORT_BIT  = 62,
  parameter int ENABLE_BIT = 61,
  parameter int EMPTY_BIT  = 30
) (
  input  logic [STATUS_W-1:0] status,
  output logic                quiet
);
  logic unused_status;
  assign unused_status = ^status;

  assign quiet = !status[DRAIN_BIT] && !status[ABORT_BIT] &&
                 !status[ENABLE_BIT] && status[EMPTY_BIT];
endmodule

// File: rtl/dma_abort_seq.sv
module dma_abort_seq
  import abort_seq_pkg::*;
#(
  parameter int STATUS_W      = 64,
  parameter int TIMEOUT_TICKS = 6,
  parameter int RETRY_MAX     = 4,
  parameter int RING_COUNT    = 256,
  parameter int LENGEN_W      = 32,
  parameter int GEN_CHECK_BIT = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                abort_req,
  input  logic                eng_disabled,
  input  logic [STATUS_W-1:0] hw_status,
  input  logic                tick,
  input  logic                shutdown,
  output logic                busy,
  output logic                flush_all,
  output logic                ptr_reset,
  output logic                lengen_wr,
  output logic [LENGEN_W-1:0] lengen_data,
  output logic                eng_enable,
  output logic                readback
);
  localparam int DL_W = $clog2(TIMEOUT_TICKS + 1);
  localparam int RT_W = $clog2(RETRY_MAX + 1);
  localparam logic [LENGEN_W-1:0] LENGEN_VAL =
    LENGEN_W'(RING_COUNT) | (LENGEN_W'(1) << GEN_CHECK_BIT);

  seq_state_e st_q, st_d;
  logic       pend_q, pend_d;
  logic       quiet, dl_zero, rt_zero;
  logic       start, dl_dec, rt_dec;

  quiesce_eval #(.STATUS_W(STATUS_W)) u_quiet (
    .status (hw_status),
    .quiet  (quiet)
  );

  assign start  = !shutdown && (st_q == S_IDLE) && (abort_req || pend_q);
  assign dl_dec = !shutdown && tick && (st_q == S_DISARM);
  assign rt_dec = !shutdown && tick && (st_q == S_CHECK) && !quiet;

  seq_down_counter #(.CW(DL_W)) u_deadline (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (DL_W'(TIMEOUT_TICKS)),
    .dec      (dl_dec),
    .zero     (dl_zero)
  );

  seq_down_counter #(.CW(RT_W)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (RT_W'(RETRY_MAX)),
    .dec      (rt_dec),
    .zero     (rt_zero)
  );

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    if (!shutdown) begin
      if (st_q != S_IDLE && abort_req)
        pend_d = 1'b1;
      unique case (st_q)
        S_IDLE:   if (start) begin st_d = S_DISARM; pend_d = 1'b0; end
        S_DISARM: if (eng_disabled || dl_zero) st_d = S_CHECK;
        S_CHECK:  if (quiet || rt_zero) st_d = S_FLUSH;
        S_FLUSH:  st_d = S_LENGEN;
        S_LENGEN: st_d = S_ENOFF;
        S_ENOFF:  st_d = S_ENON;
        S_ENON:   st_d = S_IDLE;
        default:  st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= 1'b0;
    end else if (!shutdown) begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  assign busy        = (st_q != S_IDLE);
  assign flush_all   = (st_q == S_FLUSH);
  assign ptr_reset   = (st_q == S_FLUSH);
  assign lengen_wr   = (st_q == S_LENGEN);
  assign lengen_data = LENGEN_VAL;
  assign eng_enable  = (st_q != S_ENOFF);
  assign readback    = (st_q == S_ENOFF) || (st_q == S_ENON);

  a_r3_disable_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DISARM && eng_disabled && !shutdown) |=> (st_q == S_CHECK));
  a_r5_quiet_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CHECK && quiet && !shutdown) |=> flush_all);
  a_r7_flush_then_len: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !shutdown) |=> lengen_wr);
  a_r8_len_then_off: assert property (@(posedge clk) disable iff (!rst_n)
    (lengen_wr && !shutdown) |=> !eng_enable);
  a_r8_off_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_enable && !shutdown) |=> eng_enable);
  a_r9_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || lengen_wr || readback) |-> busy);
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> $stable(st_q));
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_all, lengen_wr, !eng_enable}));
endmodule

// File: tb/sim_dma_abort_seq.sv
module sim_dma_abort_seq;
  localparam int T_TICKS = 6;
  localparam int R_MAX   = 4;
  localparam logic [31:0] LG_EXP = 32'd256 | (32'd1 << 18);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abt = 1'b0, dis = 1'b0, tk = 1'b0, shut = 1'b0;
  logic [63:0] stat = 64'd0;
  logic busy, flush, ptrr, lw, en, rb;
  logic [31:0] lgd;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";

  // model: 0 idle,1 wait-disable,2 poll,3 flush,4 len,5 off,6 on
  int ph = 0, dl = 0, rt = 0;
  bit pend = 0;

  always #10 clk = ~clk;

  dma_abort_seq u0 (
    .clk(clk), .rst_n(rst_n), .abort_req(abt), .eng_disabled(dis),
    .hw_status(stat), .tick(tk), .shutdown(shut), .busy(busy),
    .flush_all(flush), .ptr_reset(ptrr), .lengen_wr(lw),
    .lengen_data(lgd), .eng_enable(en), .readback(rb)
  );

  function automatic bit is_quiet(logic [63:0] s);
    return !s[63] && !s[62] && !s[61] && s[30];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; dl = 0; rt = 0; pend = 0;
    end else if (!shut) begin
      if (ph != 0 && abt) pend = 1;
      case (ph)
        0: if (abt || pend) begin ph = 1; dl = T_TICKS; rt = R_MAX; pend = 0; end
        1: if (dis || dl == 0) ph = 2; else if (tk) dl = dl - 1;
        2: if (is_quiet(stat) || rt == 0) ph = 3; else if (tk) rt = rt - 1;
        6: ph = 0;
        default: ph = ph + 1;
      endcase
    end
  end

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", cur_req, what, act, exp, cycles);
    end
  endtask

  task automatic step(input bit a, input bit d, input bit t, input logic [63:0] s, input bit sh);
    abt = a; dis = d; tk = t; stat = s; shut = sh;
    @(negedge clk);
    cycles++;
    cmp("busy", {31'd0, busy}, {31'd0, ph != 0});
    cmp("flush_all", {31'd0, flush}, {31'd0, ph == 3});
    cmp("ptr_reset", {31'd0, ptrr}, {31'd0, ph == 3});
    cmp("lengen_wr", {31'd0, lw}, {31'd0, ph == 4});
    cmp("eng_enable", {31'd0, en}, {31'd0, ph != 5});
    cmp("readback", {31'd0, rb}, {31'd0, ph == 5 || ph == 6});
    if (lw === 1'b1) cmp("lengen_data", lgd, LG_EXP);
  endtask

  task automatic idle(input int n, input logic [63:0] s);
    for (int i = 0; i < n; i++) step(0, 0, 0, s, 0);
  endtask

  localparam logic [63:0] QUIET = 64'h0000_0000_4000_0000;

  initial begin
    #1;
    cur_req = "R1";
    @(negedge clk);
    step(0, 0, 0, 64'd0, 0);
    step(0, 0, 0, 64'd0, 0);
    rst_n = 1'b1;
    idle(3, QUIET);

    // R2 R3 R7 R8 R9: disable arrives, status already quiet
    cur_req = "R2";
    step(1, 0, 0, QUIET, 0);
    idle(2, QUIET);
    cur_req = "R3";
    for (int i = 0; i < 10; i++) step(0, 1, 0, QUIET, 0);
    cur_req = "R7";
    idle(2, QUIET);

    // R4: disable never arrives, timeout via ticks
    cur_req = "R4";
    step(1, 0, 0, QUIET, 0);
    for (int i = 0; i < 30; i++) step(0, 0, i % 2, QUIET, 0);

    // R6: never quiescent, budget runs out
    cur_req = "R6";
    step(1, 1, 0, 64'h8000_0000_4000_0000, 0);
    for (int i = 0; i < 25; i++) step(0, 1, i % 3 == 0, 64'h8000_0000_4000_0000, 0);

    // R5: each offending bit, then quiet mid-budget
    cur_req = "R5";
    foreach (QUIET[k]) if (k == 0) begin end
    for (int b = 0; b < 4; b++) begin
      logic [63:0] bad;
      bad = (b == 0) ? 64'h4000_0000_4000_0000 :
            (b == 1) ? 64'h2000_0000_4000_0000 :
            (b == 2) ? 64'h0000_0000_0000_0000 : 64'h8000_0000_4000_0000;
      step(1, 1, 0, bad, 0);
      for (int i = 0; i < 4; i++) step(0, 1, i == 1, bad, 0);
      for (int i = 0; i < 8; i++) step(0, 1, 0, QUIET, 0);
    end

    // R11: abort during recovery gives a second pass
    cur_req = "R11";
    step(1, 0, 0, QUIET, 0);
    step(0, 1, 0, QUIET, 0);
    step(1, 1, 0, QUIET, 0);
    for (int i = 0; i < 16; i++) step(0, 1, 0, QUIET, 0);

    // R10: shutdown freezes mid-wait
    cur_req = "R10";
    step(1, 0, 0, QUIET, 0);
    step(0, 0, 1, QUIET, 0);
    for (int i = 0; i < 10; i++) step(i % 2, 1, 1, QUIET, 1);
    for (int i = 0; i < 10; i++) step(0, 1, 0, QUIET, 0);

    // R12: abort ignored in idle under shutdown
    cur_req = "R12";
    for (int i = 0; i < 3; i++) step(1, 0, 0, QUIET, 1);
    idle(5, QUIET);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule